// File: doc/BRIEF.md
# Toggle-Signalled Word Transfer Between Clock Domains

This block moves a wide data word from one clock domain into a second, unrelated clock domain. In the sending domain, a holding register takes a new word on every clock edge where the completion strobe is high. On the same edge a single flag flop inverts. A new word is therefore marked by a change of level on one wire, not by a pulse. The receiving domain passes that wire through a short chain of its own flip-flops and compares the settled level with the level seen one cycle earlier. When the two differ, the receiver copies the holding register straight into its output register and raises a valid strobe for one cycle.

The data bus is not synchronized bit by bit. The synchronizer delay gives the bus time to settle before it is sampled. This is safe only because consecutive loads are at least twelve sending-clock edges apart. The block assumes this spacing and does not detect violations of it. There is no acknowledgment path and no queue. The block is intended for 36 MHz to 100 MHz transfers and for 100 MHz to 36 MHz transfers.

Top module: `tog_bus_cdc`

## Requirements
- R1: The holding register takes `load_word` only on a `src_clk` edge where `load_en` is 1. On all other edges it keeps its value, so changes on `load_word` while `load_en` is 0 never reach `rx_word`.
- R2: Each accepted word inverts the flag line exactly once. The receiver therefore reports exactly one word for each `load_en` pulse.
- R3: The flag enters the receiving domain only through `SYNC_STAGES` flops clocked by `dst_clk`. `rx_valid` rises no more than `SYNC_STAGES`+4 receiving-clock cycles after the loading edge.
- R4: When `rx_valid` is 1, `rx_word` equals the word that was loaded. Between strobes, `rx_word` holds the last delivered word and does not change.
- R5: `rx_valid` stays high for exactly one `dst_clk` cycle per word. It is never high on two cycles in a row.
- R6: Words arrive in the order they were loaded. None is lost, none is duplicated, and no word appears that was never loaded.
- R7: Each domain has its own asynchronous active-low reset. The resets clear the flag, the synchronizer flops and both data registers to 0. After reset, `rx_valid` is 0 and `rx_word` is 0 until a word is loaded.
- R8: Transfers are correct with the sending clock at 36 MHz and the receiving clock at 100 MHz, and also with the two frequencies swapped, for any load spacing of at least twelve sending cycles.
- R9: `DATA_W` defaults to 32. Elaboration stops when `SYNC_STAGES` is below 2 or when `DATA_W` is below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sending-domain clock |
| src_rst_n | input | 1 | Sending-domain asynchronous reset, active low |
| load_en | input | 1 | Completion strobe: load `load_word` on this edge |
| load_word | input | DATA_W | Word offered by the sending domain |
| dst_clk | input | 1 | Receiving-domain clock |
| dst_rst_n | input | 1 | Receiving-domain asynchronous reset, active low |
| rx_word | output | DATA_W | Last word delivered to the receiving domain |
| rx_valid | output | 1 | One-cycle strobe marking a newly delivered word |

## Verification
Two things can happen in the same receiving cycle: the capture of the holding register, and a change on the sender's `load_word` input. The bench drives a fresh random value onto `load_word` on every sending cycle, including the idle cycles between strobes. Every capture therefore lands while the input bus is moving. The bench judges each capture against a queue of words recorded only at strobe edges. On every other receiving cycle it also checks that `rx_word` has not moved. Any leak of the live input into the output is reported as a mismatch.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
   // Fewest flops allowed on the flag path into the receiving domain
   localparam int unsigned TBC_MIN_SYNC = 2;

   // Worst-case receive latency, in receiving cycles, for a given chain depth
   function automatic int unsigned tbc_latency_bound(input int unsigned stages);
      return stages + 4;
   endfunction
endpackage

// File: rtl/tbc_src_reg.sv
module tbc_src_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_word,
   output logic [DATA_W-1:0] held_word,
   output logic              flag_lvl
);
   // Holding register: loads only on a strobe edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_word <= '0;
      end else if (load_en) begin
         held_word <= load_word;
      end
   end

   // One level change per accepted word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_lvl <= 1'b0;
      end else if (load_en) begin
         flag_lvl <= ~flag_lvl;
      end
   end
endmodule

// File: rtl/tbc_sync_chain.sv
module tbc_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] stage_q;

   // First stage samples the asynchronous flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q[0] <= 1'b0;
      end else begin
         stage_q[0] <= async_in;
      end
   end

   // Remaining stages: one flop per stage
   for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[gi] <= 1'b0;
         end else begin
            stage_q[gi] <= stage_q[gi-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/tbc_dst_capture.sv
module tbc_dst_capture #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_lvl,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_valid
);
   logic last_lvl;
   logic lvl_change;

   // Level seen one cycle earlier
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_lvl <= 1'b0;
      end else begin
         last_lvl <= sync_lvl;
      end
   end

   assign lvl_change = sync_lvl ^ last_lvl;

   // Capture the bus directly; it settled long before the flag got here
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= lvl_change;
         if (lvl_change) begin
            rx_word <= bus_in;
         end
      end
   end
endmodule

// File: rtl/tog_bus_cdc.sv
module tog_bus_cdc
   import tbc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              src_rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_word,
   input  logic              dst_clk,
   input  logic              dst_rst_n,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_valid
);
   // Elaboration-time parameter checks (R9)
   if (SYNC_STAGES < TBC_MIN_SYNC) begin : g_bad_depth
      $error("tog_bus_cdc: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tog_bus_cdc: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] held_word;
   logic              tog_line;
   logic              tog_synced;

   tbc_src_reg #(.DATA_W(DATA_W)) u_src (
      .clk       (src_clk),
      .rst_n     (src_rst_n),
      .load_en   (load_en),
      .load_word (load_word),
      .held_word (held_word),
      .flag_lvl  (tog_line)
   );

   tbc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (dst_clk),
      .rst_n    (dst_rst_n),
      .async_in (tog_line),
      .sync_out (tog_synced)
   );

   tbc_dst_capture #(.DATA_W(DATA_W)) u_dst (
      .clk      (dst_clk),
      .rst_n    (dst_rst_n),
      .sync_lvl (tog_synced),
      .bus_in   (held_word),
      .rx_word  (rx_word),
      .rx_valid (rx_valid)
   );
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
   parameter int unsigned DATA_W = 32
) (
   input logic              src_clk,
   input logic              src_rst_n,
   input logic              load_en,
   input logic              src_tog,
   input logic [DATA_W-1:0] src_held,
   input logic              dst_clk,
   input logic              dst_rst_n,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_word
);
   logic src_armed;
   logic dst_armed;

   // High from the first edge after each reset release, so $past looks only at post-reset cycles
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) src_armed <= 1'b0;
      else            src_armed <= 1'b1;
   end
   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) dst_armed <= 1'b0;
      else            dst_armed <= 1'b1;
   end

   assert_toggle_per_load_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (src_armed && $past(load_en)) |-> (src_tog != $past(src_tog)));

   assert_hold_when_idle_R1: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (src_armed && !$past(load_en)) |-> ($stable(src_held) && $stable(src_tog)));

   assert_single_cycle_valid_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      rx_valid |=> !rx_valid);

   assert_word_moves_on_valid_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      (dst_armed && !$stable(rx_word)) |-> rx_valid);

   assert_capture_equals_held_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      rx_valid |-> (rx_word == src_held));

   assert_reset_clears_R7: assert property (@(posedge dst_clk)
      !dst_rst_n |-> (!rx_valid && (rx_word == '0)));
endmodule

bind tog_bus_cdc tbc_checker #(.DATA_W(DATA_W)) u_tbc_checker (
   .src_clk   (src_clk),
   .src_rst_n (src_rst_n),
   .load_en   (load_en),
   .src_tog   (tog_line),
   .src_held  (held_word),
   .dst_clk   (dst_clk),
   .dst_rst_n (dst_rst_n),
   .rx_valid  (rx_valid),
   .rx_word   (rx_word)
);

// File: tb/tog_bus_cdc_bench.sv
`timescale 1ns/1ps
module tog_bus_cdc_bench;
   localparam int unsigned DATA_W      = 32;
   localparam int unsigned SYNC_STAGES = 2;
   localparam int          LAT_BOUND   = SYNC_STAGES + 4;
   localparam int          WORDS       = 60;

   logic clk = 1'b0;          // 50 MHz reference used for the watchdog
   logic src_clk = 1'b0;
   logic dst_clk = 1'b0;
   logic src_rst_n = 1'b0;
   logic dst_rst_n = 1'b0;
   logic load_en = 1'b0;
   logic [DATA_W-1:0] load_word = '0;
   logic [DATA_W-1:0] rx_word;
   logic rx_valid;

   real src_half = 13.889;
   real dst_half = 5.0;

   int total = 0;
   int bad = 0;
   int got = 0;
   int age = 0;
   int wd_cycles = 0;
   bit prev_valid = 1'b0;
   logic [DATA_W-1:0] model_word = '0;
   logic [DATA_W-1:0] exp_q[$];

   always #10 clk = ~clk;
   always #(src_half) src_clk = ~src_clk;
   always #(dst_half) dst_clk = ~dst_clk;

   tog_bus_cdc #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tog_bus_cdc (
      .src_clk   (src_clk),
      .src_rst_n (src_rst_n),
      .load_en   (load_en),
      .load_word (load_word),
      .dst_clk   (dst_clk),
      .dst_rst_n (dst_rst_n),
      .rx_word   (rx_word),
      .rx_valid  (rx_valid)
   );

   task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model: record each word at the edge that accepts it (R1, R2)
   always @(posedge src_clk) begin
      if (src_rst_n && load_en) begin
         exp_q.push_back(load_word);
         age = 0;
      end
   end

   // Compare on every receiving clock, away from the active edge
   always @(negedge dst_clk) begin
      if (dst_rst_n) begin
         if (exp_q.size() > 0) age++;
         if (rx_valid) begin
            check(!prev_valid, "R5 valid longer than one cycle", 32'(rx_valid), 32'(0));
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 word with nothing loaded", rx_word, model_word);
            end else begin
               logic [DATA_W-1:0] exp_w;
               exp_w = exp_q.pop_front();
               check(rx_word == exp_w, "R4 delivered word", rx_word, exp_w);
               check(age <= LAT_BOUND, "R3 latency", 32'(age), 32'(LAT_BOUND));
               model_word = exp_w;
               got++;
            end
         end else begin
            check(rx_word == model_word, "R1/R4 word held between strobes", rx_word, model_word);
         end
         prev_valid = rx_valid;
      end else begin
         prev_valid = 1'b0;
      end
   end

   // Watchdog: an expired run is a failed check and still reports
   always @(posedge clk) begin
      wd_cycles++;
      if (wd_cycles > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", wd_cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic do_reset(input real s_half, input real d_half);
      load_en = 1'b0;
      src_rst_n = 1'b0;
      dst_rst_n = 1'b0;
      src_half = s_half;
      dst_half = d_half;
      #200;
      exp_q.delete();
      model_word = '0;
      got = 0;
      @(negedge src_clk) src_rst_n = 1'b1;
      @(negedge dst_clk) dst_rst_n = 1'b1;
      // R7: reset state, and no spurious word while idle
      for (int i = 0; i < 20; i++) begin
         @(negedge dst_clk);
         check(!rx_valid, "R7 no valid after reset", 32'(rx_valid), 32'(0));
         check(rx_word == '0, "R7 word cleared", rx_word, '0);
      end
   endtask

   task automatic run_phase(input string tag);
      for (int w = 0; w < WORDS; w++) begin
         int gap;
         gap = (w % 5 == 0) ? 12 : int'($urandom_range(12, 22));
         @(negedge src_clk);
         load_en = 1'b1;
         load_word = $urandom;
         // Input bus keeps moving while idle; only strobed values may appear (R1)
         for (int c = 1; c < gap; c++) begin
            @(negedge src_clk);
            load_en = 1'b0;
            load_word = $urandom;
         end
      end
      @(negedge src_clk) load_en = 1'b0;
      repeat (40) @(negedge dst_clk);
      check(exp_q.size() == 0, {tag, " R6 all words delivered"}, 32'(exp_q.size()), 32'(0));
      check(got == WORDS, {tag, " R2 one delivery per load"}, 32'(got), 32'(WORDS));
   endtask

   initial begin
      // R8: slow sender, fast receiver (36 MHz to 100 MHz)
      do_reset(13.889, 5.0);
      run_phase("R8 36->100");
      // R8: fast sender, slow receiver (100 MHz to 36 MHz)
      do_reset(5.0, 13.889);
      run_phase("R8 100->36");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule